// File: doc/BRIEF.md
# 16-bit Arithmetic and Logic Unit with Condition Flags

This block is the purely combinational arithmetic and logic unit of a small load/store processor. A 4-bit operation code picks one of nine functions, which are applied to two 16-bit operands. The block returns a 16-bit result in the same cycle, together with a 16-bit condition word. That word holds zero, carry, negative and overflow in the low four bit positions, where the processor's status register expects to find them.

The functions are add, subtract, bitwise AND, OR and XOR, inversion, one-place logical shifts in either direction, and a byte merge. The byte merge joins the upper byte of the first operand with the lower byte of the second. The surrounding datapath registers the result and the flags. This unit holds no state.

Top module: `alu16_core`

## Requirements
- R1: Code 0000 gives `a_i + b_i` modulo 2^16, and carry (flag bit 1) is the carry out of bit 15.
- R2: Code 0001 gives `a_i - b_i` modulo 2^16, and carry (flag bit 1) is 1 exactly when `a_i >= b_i` as unsigned values (no borrow).
- R3: Overflow (flag bit 3) is 1 for add when both operands share a sign bit and the result's sign bit differs. It is 1 for subtract when the operands' sign bits differ and the result's sign bit differs from `a_i`. It is 0 for every other code.
- R4: Codes 0010, 0011 and 0101 give `a_i & b_i`, `a_i | b_i` and `a_i ^ b_i` respectively, with carry 0.
- R5: Code 0100 gives `~a_i` with carry 0, and `b_i` has no effect on any output.
- R6: Code 0110 gives `a_i` shifted right by exactly one place with a 0 entering bit 15. Carry equals `a_i[0]`, and `b_i` has no effect.
- R7: Code 0111 gives `a_i` shifted left by exactly one place with a 0 entering bit 0. Carry equals `a_i[15]`, and `b_i` has no effect.
- R8: Code 1001 gives `{a_i[15:8], b_i[7:0]}` with carry 0.
- R9: For every code, zero (flag bit 0) is 1 exactly when the result is 0, and negative (flag bit 2) equals result bit 15.
- R10: Flag bits 15 to 4 are always 0.
- R11: Codes 1000 and 1010 to 1111 give result 0 with carry 0 and overflow 0, so zero reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| result_o | output | 16 | Operation result |
| flags_o | output | 16 | Condition word: bit 0 zero, bit 1 carry, bit 2 negative, bit 3 overflow |

## Verification
Every output of the block is combinational, so the result and all four flags are due in the same cycle that the operands and code are applied, with no register in between. The bench drives each stimulus on the falling clock edge and samples on the following rising edge, half a period later, once the logic has settled. It sweeps all sixteen codes over a grid of corner operands and then over a long pseudo-random series. For every sample it compares the outputs with values it computes arithmetically.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam logic [3:0] OP_ADD = 4'h0;
  localparam logic [3:0] OP_SUB = 4'h1;
  localparam logic [3:0] OP_AND = 4'h2;
  localparam logic [3:0] OP_OR  = 4'h3;
  localparam logic [3:0] OP_NOT = 4'h4;
  localparam logic [3:0] OP_XOR = 4'h5;
  localparam logic [3:0] OP_SHR = 4'h6;
  localparam logic [3:0] OP_SHL = 4'h7;
  localparam logic [3:0] OP_MRG = 4'h9;

  localparam int FLG_Z = 0;
  localparam int FLG_C = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
  parameter int W = 16
) (
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   ext;

  // subtract as a + ~b + 1; the carry out then means "no borrow"
  assign b_eff   = sub_i ? ~b_i : b_i;
  assign ext     = {1'b0, a_i} + {1'b0, b_eff} + (W+1)'(sub_i);
  assign sum_o   = ext[W-1:0];
  assign carry_o = ext[W];
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  localparam int HB = W / 2;

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_NOT: res_o = ~a_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_SHR: begin
        res_o   = {1'b0, a_i[W-1:1]};
        carry_o = a_i[0];
      end
      OP_SHL: begin
        res_o   = {a_i[W-2:0], 1'b0};
        carry_o = a_i[W-1];
      end
      OP_MRG: res_o = {a_i[W-1:HB], b_i[HB-1:0]};
      default: begin
        res_o   = '0;
        carry_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, a_i})) begin
      assert_shr_msb_R6: assert (op_i != OP_SHR || res_o[W-1] == 1'b0)
        else $error("R6: shift right left bit %0d set", W-1);
      assert_shl_lsb_R7: assert (op_i != OP_SHL || res_o[0] == 1'b0)
        else $error("R7: shift left left bit 0 set");
      assert_mrg_hi_R8: assert (op_i != OP_MRG || res_o[W-1:HB] == a_i[W-1:HB])
        else $error("R8: merge upper byte mismatch");
    end
  end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W   = 16,
  parameter int STW = 16
) (
  input  logic [3:0]     op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   result_o,
  output logic [STW-1:0] flags_o
);
  logic         is_arith;
  logic [W-1:0] arith_res;
  logic [W-1:0] logic_res;
  logic         arith_c;
  logic         arith_v;
  logic         logic_c;

  assign is_arith = (op_i == OP_ADD) || (op_i == OP_SUB);

  alu16_arith #(.W(W)) i_arith (
    .sub_i   (op_i == OP_SUB),
    .a_i     (a_i),
    .b_i     (b_i),
    .sum_o   (arith_res),
    .carry_o (arith_c),
    .ovf_o   (arith_v)
  );

  alu16_logic #(.W(W)) i_logic (
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .res_o   (logic_res),
    .carry_o (logic_c)
  );

  always_comb begin
    result_o       = is_arith ? arith_res : logic_res;
    flags_o        = '0;
    flags_o[FLG_Z] = (result_o == '0);
    flags_o[FLG_C] = is_arith ? arith_c : logic_c;
    flags_o[FLG_N] = result_o[W-1];
    flags_o[FLG_V] = is_arith & arith_v;
  end

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i})) begin
      assert_add_carry_R1: assert (op_i != OP_ADD ||
          flags_o[FLG_C] == (({1'b0, a_i} + {1'b0, b_i}) > (W+1)'({W{1'b1}})))
        else $error("R1: add carry wrong");
      assert_sub_carry_R2: assert (op_i != OP_SUB || flags_o[FLG_C] == (a_i >= b_i))
        else $error("R2: subtract carry wrong");
      assert_no_ovf_R3: assert (is_arith || !flags_o[FLG_V])
        else $error("R3: overflow on logic code");
      assert_unused_zero_R11: assert (is_arith || op_i inside {[OP_AND:OP_SHL], OP_MRG} ||
          (result_o == '0 && flags_o[FLG_Z]))
        else $error("R11: unused code gave nonzero result");
    end
  end
endmodule

// File: tb/test_alu16_core.sv
module test_alu16_core;
  logic        clk;
  logic [3:0]  op;
  logic [15:0] a, b;
  logic [15:0] res;
  logic [15:0] flg;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  alu16_core i_alu16_core (
    .op_i(op), .a_i(a), .b_i(b), .result_o(res), .flags_o(flg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp,
                     input logic [3:0] o, input logic [15:0] x, input logic [15:0] y);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s op=%h a=%h b=%h actual=%h expected=%h", tag, o, x, y, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y);
    logic [16:0] wide;
    logic [15:0] er;
    logic        ec, ev;
    string       rtag, ctag;
    @(negedge clk);
    op = o; a = x; b = y;
    er = '0; ec = 1'b0; ev = 1'b0;
    case (o)
      4'h0: begin wide = {1'b0, x} + {1'b0, y}; er = wide[15:0]; ec = wide[16];
                  ev = (x[15] == y[15]) && (er[15] != x[15]); rtag = "R1"; ctag = "R1"; end
      4'h1: begin er = x - y; ec = (x >= y);
                  ev = (x[15] != y[15]) && (er[15] != x[15]); rtag = "R2"; ctag = "R2"; end
      4'h2: begin er = x & y; rtag = "R4"; ctag = "R4"; end
      4'h3: begin er = x | y; rtag = "R4"; ctag = "R4"; end
      4'h4: begin er = 16'hFFFF - x; rtag = "R5"; ctag = "R5"; end
      4'h5: begin er = x ^ y; rtag = "R4"; ctag = "R4"; end
      4'h6: begin er = x / 2; ec = x[0]; rtag = "R6"; ctag = "R6"; end
      4'h7: begin er = 16'((32'(x) * 2) % 65536); ec = x[15]; rtag = "R7"; ctag = "R7"; end
      4'h9: begin er = 16'(((x / 256) * 256) + (y % 256)); rtag = "R8"; ctag = "R8"; end
      default: begin er = '0; rtag = "R11"; ctag = "R11"; end
    endcase
    @(posedge clk);
    chk(rtag,  res, er, o, x, y);
    chk(ctag,  {15'd0, flg[1]}, {15'd0, ec}, o, x, y);
    chk("R3",  {15'd0, flg[3]}, {15'd0, ev}, o, x, y);
    chk("R9",  {14'd0, flg[2], flg[0]}, {14'd0, er[15], (er == 16'd0)}, o, x, y);
    chk("R10", {4'd0, flg[15:4]}, 16'd0, o, x, y);
  endtask

  logic [15:0] corners [10] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF,
                                16'h00FF, 16'hFF00, 16'h5555, 16'hAAAA, 16'h1234};

  initial begin
    logic [31:0] lf;
    op = '0; a = '0; b = '0;
    // idle state with all-zero inputs: add of zeros
    @(posedge clk);
    chk("R9", flg, 16'h0001, 4'h0, 16'h0, 16'h0);
    chk("R1", res, 16'h0000, 4'h0, 16'h0, 16'h0);
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          apply(4'(o), corners[i], corners[j]);
    // directed boundaries
    apply(4'h0, 16'h7FFF, 16'h0001);  // R3 positive overflow
    apply(4'h1, 16'h8000, 16'h0001);  // R3 negative overflow
    apply(4'h1, 16'h1234, 16'h1234);  // R2 equal operands: carry set, zero set
    apply(4'h6, 16'h0001, 16'h0000);  // R6 shift out to zero
    apply(4'h7, 16'h8000, 16'hFFFF);  // R7 shift out to zero
    // R5/R6/R7: b has no effect
    for (int o = 4; o < 8; o++) begin
      if (o == 5) continue;
      apply(4'(o), 16'hC3A5, 16'h0000);
      apply(4'(o), 16'hC3A5, 16'hFFFF);
    end
    lf = 32'h1ACE_B00C;
    for (int k = 0; k < 4000; k++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      apply(lf[3:0], lf[31:16], lf[19:4] ^ lf[15:0]);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule